// File: doc/BRIEF.md
# Memory-Mapped Event Counter Unit

The unit holds a bank of eight 64-bit counters behind a simple register port that is 64 bits wide. Each counter selects one of 256 event lines with an 8-bit selector. Selector value 0 is a built-in clock-cycle event that is always active. A counter advances by one on each clock in which three things are high: the global run bit, that counter's own enable bit and its selected event.

Software turns per-counter enables and interrupt masks on and off through separate set and clear registers, so it never needs a read-modify-write. When a counter wraps from all ones to zero, it latches a sticky overflow flag. Software clears that flag by writing a one to it. A level interrupt stays high while any flagged counter has its interrupt unmasked. A global control word gates all counting and can zero every counter in one write.

Top module: `evctr_unit`

## Requirements
- R1: After a synchronous active-high reset, every counter, selector, control field, enable, interrupt mask and overflow flag is zero and `irq` is low.
- R2: Counter n increments by one on each clock in which the global run bit, enable bit n and the selected event are all high. Selector 0 means "every clock". Selector s>0 uses `events[s]`. A disabled counter, or one whose selected event is low, holds its value.
- R3: Each counter's value is at byte offset 0x000+8n, its control word at 0x100+8n and its event selector at 0x200+8n. The selector keeps only its low 8 bits, and reads return them zero-extended.
- R4: A write to 0x410 sets enable bit n for every 1 in data bit n. A write to 0x418 clears those bits. Zero data bits leave the mask alone. Reads of either offset return the enable mask in bits 7:0.
- R5: Interrupt masks follow the same rule at 0x420 (set) and 0x428 (clear). Both offsets read back the mask.
- R6: Bit 0 of the global control word at 0x400 is the run bit and reads back. Writing bit 1 as 1 zeroes every counter in that cycle; it is not stored and reads 0. Writing 0 stops all counting and leaves the per-counter enables as they were.
- R7: Counter values are writable. A write to a counter wins over an increment in the same clock.
- R8: A counter that wraps from all ones to zero sets bit n of the overflow register at 0x440. Writing 1 to bit n clears it, and 0 bits leave it. A wrap in the same clock as a clear leaves the bit set.
- R9: `irq` is high whenever some overflow bit is set and its interrupt mask bit is also set, and low otherwise.
- R10: Reads of unmapped offsets, or of offsets whose low three bits are not zero, return 0. Writes to such offsets change nothing.
- R11: Each counter control word stores its low 8 bits, and reads return them zero-extended. A value of 0 is normal operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 12 | Byte offset of the register access |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data for `addr`, combinational |
| events | input | 256 | Event lines; bit 0 is unused because selector 0 is the cycle event |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the exact count over a gated window. A design that counted on the edge that cleared the run bit, or skipped it, would be off by one. It presets a counter two below the wrap point to expose a missed or mistimed overflow flag, and writes a counter while it is running to catch an increment that overrides the load. It also writes the wrong bit to the overflow register, masks and unmasks the interrupt, and checks that stopping globally keeps the enable mask. These catch a clear that wipes the whole register, an unmasked `irq`, or a global stop that clobbers the enables.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
    localparam int NUM_CNT = 8;
    localparam int CNT_W   = 64;
    localparam int DATA_W  = 64;
    localparam int SEL_W   = 8;
    localparam int NUM_EV  = 1 << SEL_W;
    localparam int CTL_W   = 8;
    localparam int ADDR_W  = 12;
    localparam int IDX_W   = $clog2(NUM_CNT);
    localparam int WORD_W  = ADDR_W - 3;

    // word (8-byte) offsets of the register groups
    localparam logic [WORD_W-1:0] W_VALUE = 9'h000;
    localparam logic [WORD_W-1:0] W_CTL   = 9'h020;
    localparam logic [WORD_W-1:0] W_EVT   = 9'h040;
    localparam logic [WORD_W-1:0] W_GCTL  = 9'h080;
    localparam logic [WORD_W-1:0] W_ENSET = 9'h082;
    localparam logic [WORD_W-1:0] W_ENCLR = 9'h083;
    localparam logic [WORD_W-1:0] W_IESET = 9'h084;
    localparam logic [WORD_W-1:0] W_IECLR = 9'h085;
    localparam logic [WORD_W-1:0] W_OVS   = 9'h088;

    typedef enum logic [3:0] {
        RK_NONE, RK_VALUE, RK_CTL, RK_EVT, RK_GCTL,
        RK_ENSET, RK_ENCLR, RK_IESET, RK_IECLR, RK_OVS
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t         r;
        logic [WORD_W-1:0] w;
        w      = a[ADDR_W-1:3];
        r.kind = RK_NONE;
        r.idx  = w[IDX_W-1:0];
        if (a[2:0] == 3'b000) begin
            if      ((w >> IDX_W) == (W_VALUE >> IDX_W)) r.kind = RK_VALUE;
            else if ((w >> IDX_W) == (W_CTL   >> IDX_W)) r.kind = RK_CTL;
            else if ((w >> IDX_W) == (W_EVT   >> IDX_W)) r.kind = RK_EVT;
            else if (w == W_GCTL)  r.kind = RK_GCTL;
            else if (w == W_ENSET) r.kind = RK_ENSET;
            else if (w == W_ENCLR) r.kind = RK_ENCLR;
            else if (w == W_IESET) r.kind = RK_IESET;
            else if (w == W_IECLR) r.kind = RK_IECLR;
            else if (w == W_OVS)   r.kind = RK_OVS;
        end
        return r;
    endfunction
endpackage

// File: rtl/evctr_mask.sv
module evctr_mask #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [N-1:0] bits,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (set_we) q <= q | bits;
        else if (clr_we) q <= q & ~bits;
    end

    // R4 (and R5 for the interrupt mask instance)
    p_set_r4: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((q & $past(bits)) == $past(bits)));
    p_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((q & $past(bits)) == '0));
endmodule

// File: rtl/evctr_cell.sv
module evctr_cell
    import evctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [NUM_EV-1:0] events,
    input  logic              ld_val,
    input  logic              ld_sel,
    input  logic              ld_ctl,
    input  logic              zero_all,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  value,
    output logic [SEL_W-1:0]  sel,
    output logic [CTL_W-1:0]  ctl,
    output logic              wrap
);
    logic ev_hit, bump;

    always_comb begin
        ev_hit = (sel == '0) ? 1'b1 : events[sel];
        bump   = run && ev_hit && !ld_val && !zero_all;
        wrap   = bump && (&value);
    end

    always_ff @(posedge clk) begin
        if (rst)           value <= '0;
        else if (ld_val)   value <= wdata[CNT_W-1:0];
        else if (zero_all) value <= '0;
        else if (bump)     value <= value + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
            ctl <= '0;
        end else begin
            if (ld_sel) sel <= wdata[SEL_W-1:0];
            if (ld_ctl) ctl <= wdata[CTL_W-1:0];
        end
    end

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ld_val && !zero_all && !run) |=> $stable(value));
    p_load_wins_r7: assert property (@(posedge clk) disable iff (rst)
        ld_val |=> (value == $past(wdata[CNT_W-1:0])));
endmodule

// File: rtl/evctr_unit.sv
module evctr_unit
    import evctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_EV-1:0] events,
    output logic              irq
);
    reg_sel_t           rs;
    logic               run_q;
    logic               zero_all;
    logic [NUM_CNT-1:0] en_q, ie_q, ovs_q, wrap;
    logic               en_set, en_clr, ie_set, ie_clr, ovs_w1c;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];
    logic [SEL_W-1:0]   cnt_sel [NUM_CNT];
    logic [CTL_W-1:0]   cnt_ctl [NUM_CNT];
    logic [CNT_W-1:0]   val_or;

    always_comb begin
        rs       = decode_addr(addr);
        zero_all = wr_en && (rs.kind == RK_GCTL) && wdata[1];
        en_set   = wr_en && (rs.kind == RK_ENSET);
        en_clr   = wr_en && (rs.kind == RK_ENCLR);
        ie_set   = wr_en && (rs.kind == RK_IESET);
        ie_clr   = wr_en && (rs.kind == RK_IECLR);
        ovs_w1c  = wr_en && (rs.kind == RK_OVS);
    end

    always_ff @(posedge clk) begin
        if (rst)                                 run_q <= 1'b0;
        else if (wr_en && rs.kind == RK_GCTL)    run_q <= wdata[0];
    end

    evctr_mask #(.N(NUM_CNT)) u_en (
        .clk(clk), .rst(rst), .set_we(en_set), .clr_we(en_clr),
        .bits(wdata[NUM_CNT-1:0]), .q(en_q));

    evctr_mask #(.N(NUM_CNT)) u_ie (
        .clk(clk), .rst(rst), .set_we(ie_set), .clr_we(ie_clr),
        .bits(wdata[NUM_CNT-1:0]), .q(ie_q));

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        evctr_cell u_cell (
            .clk(clk), .rst(rst),
            .run(run_q && en_q[i]),
            .events(events),
            .ld_val(wr_en && rs.kind == RK_VALUE && rs.idx == IDX_W'(i)),
            .ld_sel(wr_en && rs.kind == RK_EVT   && rs.idx == IDX_W'(i)),
            .ld_ctl(wr_en && rs.kind == RK_CTL   && rs.idx == IDX_W'(i)),
            .zero_all(zero_all),
            .wdata(wdata),
            .value(cnt_val[i]),
            .sel(cnt_sel[i]),
            .ctl(cnt_ctl[i]),
            .wrap(wrap[i]));
    end

    // a wrap in the same clock as a write-one-to-clear keeps the flag
    always_ff @(posedge clk) begin
        if (rst) ovs_q <= '0;
        else     ovs_q <= (ovs_q & ~(ovs_w1c ? wdata[NUM_CNT-1:0] : '0)) | wrap;
    end

    assign irq = |(ovs_q & ie_q);

    always_comb begin
        rdata = '0;
        unique case (rs.kind)
            RK_VALUE:          rdata = DATA_W'(cnt_val[rs.idx]);
            RK_CTL:            rdata = DATA_W'(cnt_ctl[rs.idx]);
            RK_EVT:            rdata = DATA_W'(cnt_sel[rs.idx]);
            RK_GCTL:           rdata = DATA_W'(run_q);
            RK_ENSET, RK_ENCLR: rdata = DATA_W'(en_q);
            RK_IESET, RK_IECLR: rdata = DATA_W'(ie_q);
            RK_OVS:            rdata = DATA_W'(ovs_q);
            default:           rdata = '0;
        endcase
    end

    always_comb begin
        val_or = '0;
        for (int i = 0; i < NUM_CNT; i++) val_or = val_or | cnt_val[i];
    end

    p_wrap_flags_r8: assert property (@(posedge clk) disable iff (rst)
        (|wrap) |=> ((ovs_q & $past(wrap)) == $past(wrap)));
    p_irq_on_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        ((|(wrap & ie_q)) && !ie_clr) |=> irq);
    p_zero_all_r6: assert property (@(posedge clk) disable iff (rst)
        zero_all |=> (val_or == '0));
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!irq && !run_q && en_q == '0));
endmodule

// File: tb/test_evctr_unit.sv
`timescale 1ns/1ps
module test_evctr_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [255:0] events = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] q_exp [$];
    bit          q_irq [$];
    string       q_tag [$];

    always #2.5 clk = ~clk;

    evctr_unit i_evctr_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .events(events), .irq(irq));

    // driver tasks: entered and left at a falling edge, one rising edge each
    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [63:0] e, input string tag);
        addr = a;
        q_exp.push_back(e); q_irq.push_back(1'b0); q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic expect_irq(input logic e, input string tag);
        q_exp.push_back({63'd0, e}); q_irq.push_back(1'b1); q_tag.push_back(tag);
        @(negedge clk);
    endtask

    // monitor: pops one expected item per rising edge that has one queued
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() != 0) begin
                logic [63:0] e, got;
                bit          isi;
                string       t;
                e = q_exp.pop_front(); isi = q_irq.pop_front(); t = q_tag.pop_front();
                got = isi ? {63'd0, irq} : rdata;
                checks++;
                if (got !== e) begin
                    errors++;
                    $display("FAIL %s: got 0x%0h expected 0x%0h", t, got, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_rd(12'h000, 64'd0, "R1 counter0");
        expect_rd(12'h410, 64'd0, "R1 enables");
        expect_rd(12'h440, 64'd0, "R1 overflow");
        expect_irq(1'b0, "R1 irq");
        // R3 selector keeps 8 bits, R11 control keeps 8 bits
        wr(12'h208, 64'h1FF06);
        expect_rd(12'h208, 64'h06, "R3 selector low bits");
        wr(12'h110, 64'hABC3A);
        expect_rd(12'h110, 64'h3A, "R11 control readback");
        wr(12'h110, 64'h0);
        wr(12'h218, 64'd5);
        // R4 set/clear enables
        wr(12'h410, 64'h05);
        expect_rd(12'h410, 64'h05, "R4 set");
        wr(12'h410, 64'h0A);
        expect_rd(12'h418, 64'h0F, "R4 set keeps zeros");
        wr(12'h418, 64'h04);
        expect_rd(12'h410, 64'h0B, "R4 clear");
        // R2 gated counting: c0 cycles, c1 sel6 low, c2 disabled, c3 sel5 high
        events[5] = 1'b1;
        wr(12'h018, 64'd100);
        wr(12'h400, 64'h1);
        idle(10);
        wr(12'h400, 64'h0);
        expect_rd(12'h000, 64'd11, "R2 cycle event");
        expect_rd(12'h008, 64'd0, "R2 event low");
        expect_rd(12'h010, 64'd0, "R2 counter disabled");
        expect_rd(12'h018, 64'd111, "R2 external event");
        // R6 global stop keeps enables and freezes counts
        idle(3);
        expect_rd(12'h000, 64'd11, "R6 stopped");
        expect_rd(12'h410, 64'h0B, "R6 enables kept");
        // R7 write wins over increment
        wr(12'h400, 64'h1);
        wr(12'h000, 64'd500);
        wr(12'h400, 64'h0);
        expect_rd(12'h000, 64'd501, "R7 load priority");
        // R8/R9 overflow and interrupt
        wr(12'h020, 64'hFFFF_FFFF_FFFF_FFFE);
        wr(12'h410, 64'h10);
        wr(12'h420, 64'h10);
        expect_irq(1'b0, "R9 before wrap");
        wr(12'h400, 64'h1);
        idle(1);
        wr(12'h400, 64'h0);
        expect_rd(12'h020, 64'd0, "R8 wrapped value");
        expect_rd(12'h440, 64'h10, "R8 overflow flag");
        expect_irq(1'b1, "R9 irq raised");
        wr(12'h428, 64'h10);
        expect_rd(12'h420, 64'h0, "R5 mask cleared");
        expect_irq(1'b0, "R9 masked");
        wr(12'h420, 64'h10);
        expect_rd(12'h428, 64'h10, "R5 mask set");
        expect_irq(1'b1, "R9 unmasked");
        wr(12'h440, 64'h01);
        expect_rd(12'h440, 64'h10, "R8 other bit clear");
        wr(12'h440, 64'h10);
        expect_rd(12'h440, 64'h0, "R8 w1c");
        expect_irq(1'b0, "R9 after clear");
        // R6 run bit readback and clear-all pulse
        wr(12'h400, 64'h1);
        expect_rd(12'h400, 64'h1, "R6 run readback");
        wr(12'h400, 64'h2);
        expect_rd(12'h400, 64'h0, "R6 clear bit not stored");
        expect_rd(12'h018, 64'd0, "R6 counter3 zeroed");
        expect_rd(12'h000, 64'd0, "R6 counter0 zeroed");
        // R10 unmapped and misaligned
        wr(12'h804, 64'hFF);
        expect_rd(12'h408, 64'd0, "R10 unmapped");
        expect_rd(12'h800, 64'd0, "R10 high unmapped");
        expect_rd(12'h004, 64'd0, "R10 misaligned");
        expect_rd(12'h410, 64'h1B, "R10 write ignored");
        idle(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule